// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter Stage

The block is a synchronous binary up-counter of parameterised width. Its default width is 4. Every change of its stored value happens on a rising clock edge. On that edge the stage does one of four things, in a fixed order of priority:

- it clears to zero,
- it takes a parallel value from its data inputs,
- it steps by one,
- it keeps its value.

Two count enables control stepping. One enable is shared across a chain of stages. The other enable gates the stage's carry output.

The carry output is a plain combinational level. It is high when the stage holds its all-ones value and the carry-gating enable is high. To build a wider counter, connect each stage's carry to the next stage's carry-gating enable, and share the clock and the other enable across all stages. The result counts as one wider binary counter with no glue logic.

The clear is synchronous, so feeding a low-active decode of a chosen value back into the clear input shortens the count cycle. Control and data pins are plain levels sampled at the clock edge, and there is no handshake. The block has no asynchronous reset. Its stored value is undefined until the first clear.

Top module: `bincnt_stage`

## Requirements
- R1: When clr_n is low at a rising edge, q is all zeros after that edge, whatever load_n, enp, ent and data are.
- R2: When clr_n is high and load_n is low at a rising edge, q equals data after that edge, whatever enp and ent are.
- R3: When clr_n, load_n, enp and ent are all high at a rising edge, q becomes q+1 modulo 2^WIDTH, so all ones wraps to zero.
- R4: When clr_n and load_n are high and enp or ent is low at a rising edge, q keeps its value.
- R5: rco is high exactly when ent is high and q is all ones. It follows ent without waiting for a clock, and enp has no effect on it.
- R6: At WIDTH=4, the following sequence gives q = 13, 14, 15, 0, 1, 2 on successive edges: a clear, then a load of 12, then counting with both enables high. rco is high only in the cycle where q is 15.
- R7: With clr_n driven by a low-active decode of q==9 and both enables high, a 4-bit stage cycles 0..9 and then returns to 0. rco stays low throughout.
- R8: With two stages chained (the low stage's rco drives the high stage's ent, and enp, clk, clr_n and load_n are shared), the combined 8-bit value counts, loads and clears as one counter. The upper stage steps only when the lower stage is all ones and ent of the low stage is high. The final rco is high only at 255.
- R9: Changing clr_n, load_n, enp, ent or data between clock edges leaves q unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| enp | input | 1 | Count enable shared across a chain |
| ent | input | 1 | Count enable that also gates rco |
| data | input | WIDTH | Parallel load value |
| q | output | WIDTH | Counter value |
| rco | output | 1 | Carry level: ent high and q all ones |

## Verification
Every instance in the bench uses the default WIDTH of 4. At that width, a wrap from 15 to 0 is only sixteen counts away, so random stimulus crosses the terminal count, and raises rco, many times. The fixed 12-to-2 sequence can also be matched value for value. Two 4-bit stages chained through rco give an 8-bit counter, whose 255-to-0 rollover and upper-stage stepping are reached within a few hundred cycles. A third stage with a decode of 9 on its clear exercises the shortened count cycle.

// File: rtl/bincnt_pkg.sv
`timescale 1ns/1ps
package bincnt_pkg;
  // Operation chosen for the next edge, listed in rising priority
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/bincnt_mode_dec.sv
`timescale 1ns/1ps
module bincnt_mode_dec
  import bincnt_pkg::*;
(
  input  logic    clr_n,
  input  logic    load_n,
  input  logic    enp,
  input  logic    ent,
  output cnt_op_e op
);
  // Clear beats load, load beats the enables.
  always_comb begin
    if (!clr_n)          op = OP_CLEAR;
    else if (!load_n)    op = OP_LOAD;
    else if (enp && ent) op = OP_COUNT;
    else                 op = OP_HOLD;
  end
endmodule

// File: rtl/bincnt_lookahead.sv
`timescale 1ns/1ps
module bincnt_lookahead #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] tog,
  output logic             all_ones
);
  // chain[i] is high when every bit below i is set
  logic [WIDTH:0] chain;
  assign chain[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_prefix
    assign chain[i+1] = chain[i] & q[i];
    assign tog[i]     = chain[i];
  end

  assign all_ones = chain[WIDTH];
endmodule

// File: rtl/bincnt_cell.sv
`timescale 1ns/1ps
module bincnt_cell
  import bincnt_pkg::*;
(
  input  logic    clk,
  input  cnt_op_e op,
  input  logic    d,
  input  logic    tog,
  output logic    q
);
  // One state bit: clear, load, toggle or keep
  always_ff @(posedge clk) begin
    unique case (op)
      OP_CLEAR: q <= 1'b0;
      OP_LOAD:  q <= d;
      OP_COUNT: q <= q ^ tog;
      default:  q <= q;
    endcase
  end
endmodule

// File: rtl/bincnt_stage.sv
`timescale 1ns/1ps
module bincnt_stage
  import bincnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             enp,
  input  logic             ent,
  input  logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] q,
  output logic             rco
);
  cnt_op_e          op;
  logic [WIDTH-1:0] tog;
  logic             all_ones;

  bincnt_mode_dec u_dec (
    .clr_n  (clr_n),
    .load_n (load_n),
    .enp    (enp),
    .ent    (ent),
    .op     (op)
  );

  bincnt_lookahead #(.WIDTH(WIDTH)) u_la (
    .q        (q),
    .tog      (tog),
    .all_ones (all_ones)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    bincnt_cell u_cell (
      .clk (clk),
      .op  (op),
      .d   (data[i]),
      .tog (tog[i]),
      .q   (q[i])
    );
  end

  // Carry level, gated only by the trickle enable
  assign rco = ent & all_ones;
endmodule

// File: rtl/bincnt_stage_chk.sv
`timescale 1ns/1ps
module bincnt_stage_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic             enp,
  input logic             ent,
  input logic [WIDTH-1:0] data,
  input logic [WIDTH-1:0] q,
  input logic             rco
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  // State is undefined until the first clear has been seen
  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (!clr_n) armed <= 1'b1;
  end

  // R1
  clear_wins_chk: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> q == '0);

  // R2
  load_takes_data_chk: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !load_n) |=> q == $past(data));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && enp && ent) |=> q == $past(q) + ONE);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && !(enp && ent)) |=> $stable(q));

  // R5
  carry_level_chk: assert property (@(posedge clk) disable iff (!armed)
    rco == (ent && (q == '1)));
endmodule

bind bincnt_stage bincnt_stage_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .clr_n  (clr_n),
  .load_n (load_n),
  .enp    (enp),
  .ent    (ent),
  .data   (data),
  .q      (q),
  .rco    (rco)
);

// File: tb/sim_bincnt_stage.sv
`timescale 1ns/1ps
module sim_bincnt_stage;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int  vectors = 0;
  int  misses  = 0;
  bit  done    = 1'b0;

  // single stage
  logic s_clr_n, s_load_n, s_enp, s_ent, s_rco;
  logic [3:0] s_data, s_q;
  // two-stage chain
  logic c_clr_n, c_load_n, c_enp, c_ent, c_mid, c_rco;
  logic [7:0] c_data, c_q;
  // modulus-10 stage
  logic m_arm, m_clr_n, m_rco;
  logic [3:0] m_q;

  bincnt_stage #(.WIDTH(4)) u0 (
    .clk(clk), .clr_n(s_clr_n), .load_n(s_load_n), .enp(s_enp), .ent(s_ent),
    .data(s_data), .q(s_q), .rco(s_rco));

  bincnt_stage #(.WIDTH(4)) u_lo (
    .clk(clk), .clr_n(c_clr_n), .load_n(c_load_n), .enp(c_enp), .ent(c_ent),
    .data(c_data[3:0]), .q(c_q[3:0]), .rco(c_mid));

  bincnt_stage #(.WIDTH(4)) u_hi (
    .clk(clk), .clr_n(c_clr_n), .load_n(c_load_n), .enp(c_enp), .ent(c_mid),
    .data(c_data[7:4]), .q(c_q[7:4]), .rco(c_rco));

  assign m_clr_n = m_arm & ~(m_q == 4'd9);
  bincnt_stage #(.WIDTH(4)) u_mod (
    .clk(clk), .clr_n(m_clr_n), .load_n(1'b1), .enp(1'b1), .ent(1'b1),
    .data(4'd0), .q(m_q), .rco(m_rco));

  // reference state
  int s_ref = 0; bit s_known = 1'b0;
  int c_ref = 0; bit c_known = 1'b0;
  int m_ref = 0; bit m_known = 1'b0;

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
  endtask

  // One clock: update models at the edge, optionally disturb inputs
  // inside the high phase, then compare at the falling edge.
  task automatic step(bit perturb);
    string tq;
    string tc;
    logic [3:0] keep_d;
    logic keep_c, keep_l, keep_p, keep_t;
    @(posedge clk);
    if (!s_clr_n) begin s_ref = 0; s_known = 1'b1; tq = "R1 clear"; end
    else if (!s_load_n) begin s_ref = int'(s_data); tq = "R2 load"; end
    else if (s_enp && s_ent) begin s_ref = (s_ref + 1) % 16; tq = "R3 count"; end
    else tq = "R4 hold";

    if (!c_clr_n) begin c_ref = 0; c_known = 1'b1; tc = "R8 chain clear"; end
    else if (!c_load_n) begin c_ref = int'(c_data); tc = "R8 chain load"; end
    else if (c_enp && c_ent) begin c_ref = (c_ref + 1) % 256; tc = "R8 chain count"; end
    else tc = "R8 chain hold";

    if (!m_arm) begin m_ref = 0; m_known = 1'b1; end
    else if (m_known) m_ref = (m_ref == 9) ? 0 : m_ref + 1;

    if (perturb) begin
      #1;
      keep_c = s_clr_n; keep_l = s_load_n; keep_p = s_enp; keep_t = s_ent;
      keep_d = s_data;
      s_clr_n = ~s_clr_n; s_load_n = ~s_load_n; s_enp = ~s_enp;
      s_data = ~s_data;
      #1;
      if (s_known) chk("R9 between edges", int'(s_q), s_ref);
      s_clr_n = keep_c; s_load_n = keep_l; s_enp = keep_p; s_ent = keep_t;
      s_data = keep_d;
    end

    @(negedge clk);
    if (s_known) begin
      chk(tq, int'(s_q), s_ref);
      chk("R5 carry", int'(s_rco), int'(s_ent && s_ref == 15));
    end
    if (c_known) begin
      chk(tc, int'(c_q), c_ref);
      chk("R8 chain carry", int'(c_rco), int'(c_ent && c_ref == 255));
    end
    if (m_known) begin
      chk("R7 modulus", int'(m_q), m_ref);
      chk("R7 modulus carry", int'(m_rco), 0);
    end
  endtask

  initial begin
    int seq[6];
    seq = '{13, 14, 15, 0, 1, 2};
    s_clr_n = 1'b0; s_load_n = 1'b1; s_enp = 1'b0; s_ent = 1'b0; s_data = 4'd0;
    c_clr_n = 1'b0; c_load_n = 1'b1; c_enp = 1'b1; c_ent = 1'b1; c_data = 8'd0;
    m_arm = 1'b0;
    @(negedge clk);
    step(1'b0);
    // R1 reset state after the first clear
    chk("R1 reset state", int'(s_q), 0);
    m_arm = 1'b1;
    c_clr_n = 1'b1;

    // R2: load with both enables low
    s_clr_n = 1'b1; s_load_n = 1'b0; s_data = 4'd9; s_enp = 1'b0; s_ent = 1'b0;
    step(1'b0);
    chk("R2 load ignores enables", int'(s_q), 9);

    // R1: clear and load together, enables high
    s_clr_n = 1'b0; s_load_n = 1'b0; s_data = 4'd5; s_enp = 1'b1; s_ent = 1'b1;
    step(1'b0);
    chk("R1 clear beats load", int'(s_q), 0);

    // R6: preset 12 and count through the wrap
    s_clr_n = 1'b1; s_load_n = 1'b0; s_data = 4'd12;
    step(1'b0);
    chk("R6 preset", int'(s_q), 12);
    s_load_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      step(1'b0);
      chk("R6 sequence", int'(s_q), seq[k]);
      chk("R6 carry", int'(s_rco), int'(seq[k] == 15));
    end

    // R5: carry at 15 with enp low, then ent dropped
    s_load_n = 1'b0; s_data = 4'd15;
    step(1'b0);
    s_load_n = 1'b1; s_enp = 1'b0; s_ent = 1'b1;
    step(1'b0);
    chk("R5 carry ignores enp", int'(s_rco), 1);
    s_enp = 1'b1; s_ent = 1'b0;
    #1;
    chk("R5 carry follows ent", int'(s_rco), 0);
    step(1'b0);
    chk("R4 hold with ent low", int'(s_q), 15);

    // R8: preset chain near rollover
    c_load_n = 1'b0; c_data = 8'd253;
    step(1'b0);
    c_load_n = 1'b1;

    // random phase
    for (int n = 0; n < 1500; n++) begin
      s_clr_n  = ($urandom % 10) != 0;
      s_load_n = ($urandom % 5) != 0;
      if (n % 40 == 0) begin s_clr_n = 1'b0; s_load_n = 1'b0; end
      s_enp  = ($urandom % 4) != 0;
      s_ent  = ($urandom % 4) != 0;
      s_data = 4'($urandom);
      c_clr_n  = ($urandom % 300) != 0;
      c_load_n = ($urandom % 150) != 0;
      c_enp  = ($urandom % 8) != 0;
      c_ent  = ($urandom % 10) != 0;
      c_data = 8'($urandom);
      step(n % 7 == 3);
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog (all): actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule